// File: doc/BRIEF.md
# Dual-Partition Word Store with Top-Bit Selector

This block is a clocked, synthesizable 8192-word by 24-bit memory. The top bit of its 13-bit word address comes from one of two inputs, picked while the block runs by a selector control. With the selector low, a plain address bit supplies bit 12. With the selector high, a partition-select line supplies it instead. Software can therefore keep scalar operands in the lower half and vector operands in the upper half of the same storage. It can move between them by toggling the partition line, with no change to the twelve low address bits.

Access is gated by two chip enables. One is active low and the other active high, and the word store is selected only when both are asserted. While it is deselected, the block sits in standby: every other control is ignored and nothing is driven. Once selected, a low write strobe stores the write bus on the next rising clock edge, whatever the output enable says. A high write strobe with a low output enable reads the word. Read data is registered and appears one cycle after the request, together with a drive flag. The drive flag stands in for enabling a three-state bus.

Top module: `split_bank_sram`

## Requirements
- R1: The effective word address is {bit12, addr_lo}. Bit12 is part_sel_in when mux_ctl is 1 and a12_in when mux_ctl is 0. The other candidate input has no effect.
- R2: The block is selected only when ce1_n is 0 and ce2 is 1. The standby output is 1 in the same cycle whenever this selection condition is false, and 0 otherwise.
- R3: While the block is deselected, no write takes place and the read data stays undriven, whatever we_n, oe_n and mux_ctl are. The bench checks this by reading the address back later.
- R4: When the block is selected with we_n = 1 and oe_n = 1, no write takes place. In the next cycle, rd_drive is 0.
- R5: When the block is selected with we_n = 0, wdata is stored at the effective address on the rising edge, for either value of oe_n. In the next cycle, rd_drive is 0.
- R6: When the block is selected with we_n = 1 and oe_n = 0, the next cycle shows rd_drive = 1 and rdata holding the word at the effective address as it was at that edge.
- R7: Whenever rd_drive is 0, rdata is all zeros.
- R8: Synchronous active-high reset forces rd_drive to 0 and rdata to zero from the first edge at which rst is sampled high. No write happens while rst is 1.
- R9: A word written through one top-bit source can be read through the other source when both give the same effective bit 12. The two sources share one storage array.
- R10: A read issued in the cycle right after a write to the same address returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_lo | input | 12 | Low twelve word-address bits |
| a12_in | input | 1 | Plain candidate for address bit 12 |
| part_sel_in | input | 1 | Partition-select candidate for address bit 12 |
| mux_ctl | input | 1 | 1 selects part_sel_in, 0 selects a12_in |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| wdata | input | 24 | Write data |
| rdata | output | 24 | Registered read data, zero when not driven |
| rd_drive | output | 1 | Read data is driven (stands in for the three-state enable) |
| standby | output | 1 | Selection condition is false |

## Verification
The bench writes four distinct words. Two go through the plain bit-12 path and two through the partition path, and the inactive candidate is always held at the opposite value. A selector wired the wrong way round, or inverted, therefore returns the wrong partition's word. Write and read attempts are also made with each chip enable dropped on its own. A design that decodes only one enable, or lets a deselected write through, alters a word that is read back later. The bench also covers a write with the output enable asserted and a read straight after a write. These catch a design that lets the output enable veto writes, and one that returns the stale word. Finally, it covers the first and last addresses and a sweep over all column positions of a row. These expose a design whose row and column slicing is wrong.

// File: rtl/split_bank_pkg.sv
package split_bank_pkg;

    localparam int WORD_W   = 24;
    localparam int LO_W     = 12;
    localparam int ADDR_W   = LO_W + 1;
    localparam int COL_BITS = 5;
    localparam int ROW_BITS = ADDR_W - COL_BITS;

    typedef enum logic [1:0] {
        MD_STANDBY = 2'd0,
        MD_QUIET   = 2'd1,
        MD_WRITE   = 2'd2,
        MD_READ    = 2'd3
    } acc_mode_e;

    typedef struct packed {
        logic [ROW_BITS-1:0] row;
        logic [COL_BITS-1:0] col;
    } word_loc_t;

    function automatic word_loc_t split_loc(input logic [ADDR_W-1:0] a);
        word_loc_t l;
        l.row = a[ADDR_W-1:COL_BITS];
        l.col = a[COL_BITS-1:0];
        return l;
    endfunction

endpackage

// File: rtl/sbs_mode_decode.sv
module sbs_mode_decode
    import split_bank_pkg::*;
(
    input  logic      ce1_n,
    input  logic      ce2,
    input  logic      oe_n,
    input  logic      we_n,
    output acc_mode_e mode
);
    logic picked;

    always_comb begin
        picked = !ce1_n && ce2;
        if (!picked)
            mode = MD_STANDBY;
        else if (!we_n)
            mode = MD_WRITE;
        else if (!oe_n)
            mode = MD_READ;
        else
            mode = MD_QUIET;
    end

    always_comb begin
        if (!ce1_n && ce2 && !we_n)
            a_r5_write_beats_oe: assert (mode == MD_WRITE);
    end
endmodule

// File: rtl/sbs_top_bit_mux.sv
module sbs_top_bit_mux
    import split_bank_pkg::*;
(
    input  logic [LO_W-1:0]   addr_lo,
    input  logic              a12_in,
    input  logic              part_sel_in,
    input  logic              mux_ctl,
    output logic [ADDR_W-1:0] eff_addr
);
    logic top_bit;

    always_comb begin
        top_bit  = mux_ctl ? part_sel_in : a12_in;
        eff_addr = {top_bit, addr_lo};
    end
endmodule

// File: rtl/sbs_row_array.sv
module sbs_row_array
    import split_bank_pkg::*;
#(
    parameter int P_WORD_W   = WORD_W,
    parameter int P_ROW_BITS = ROW_BITS,
    parameter int P_COL_BITS = COL_BITS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  acc_mode_e             mode,
    input  logic [P_ROW_BITS-1:0] row,
    input  logic [P_COL_BITS-1:0] col,
    input  logic [P_WORD_W-1:0]   wdata,
    output logic [P_WORD_W-1:0]   rdata,
    output logic                  rd_drive
);
    localparam int ROWS   = 1 << P_ROW_BITS;
    localparam int COLS   = 1 << P_COL_BITS;
    localparam int ROW_W  = P_WORD_W * COLS;

    logic [ROW_W-1:0]    cells [ROWS];
    logic [P_WORD_W-1:0] pick_word;
    int                  lane_base;

    always_comb begin
        lane_base = int'(col) * P_WORD_W;
        pick_word = cells[row][lane_base +: P_WORD_W];
    end

    always_ff @(posedge clk) begin
        if (!rst && mode == MD_WRITE)
            cells[row][lane_base +: P_WORD_W] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_drive <= 1'b0;
            rdata    <= '0;
        end else if (mode == MD_READ) begin
            rd_drive <= 1'b1;
            rdata    <= pick_word;
        end else begin
            rd_drive <= 1'b0;
            rdata    <= '0;
        end
    end

    a_r6_read_drives: assert property (@(posedge clk) disable iff (rst)
        mode == MD_READ |=> rd_drive);
    a_r4_quiet_undriven: assert property (@(posedge clk) disable iff (rst)
        mode == MD_QUIET |=> !rd_drive);
    a_r5_write_undriven: assert property (@(posedge clk) disable iff (rst)
        mode == MD_WRITE |=> !rd_drive);
    a_r10_fresh_word: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_READ && $past(mode) == MD_WRITE && $past({row, col}) == {row, col})
        |=> rdata == $past(wdata, 2));
endmodule

// File: rtl/split_bank_sram.sv
module split_bank_sram
    import split_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LO_W-1:0]   addr_lo,
    input  logic              a12_in,
    input  logic              part_sel_in,
    input  logic              mux_ctl,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              rd_drive,
    output logic              standby
);
    acc_mode_e         mode;
    logic [ADDR_W-1:0] eff_addr;
    word_loc_t         loc;

    sbs_mode_decode u_decode (
        .ce1_n (ce1_n),
        .ce2   (ce2),
        .oe_n  (oe_n),
        .we_n  (we_n),
        .mode  (mode)
    );

    sbs_top_bit_mux u_mux (
        .addr_lo     (addr_lo),
        .a12_in      (a12_in),
        .part_sel_in (part_sel_in),
        .mux_ctl     (mux_ctl),
        .eff_addr    (eff_addr)
    );

    always_comb begin
        loc     = split_loc(eff_addr);
        standby = (mode == MD_STANDBY);
    end

    sbs_row_array u_array (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .row      (loc.row),
        .col      (loc.col),
        .wdata    (wdata),
        .rdata    (rdata),
        .rd_drive (rd_drive)
    );

    a_r7_zero_when_undriven: assert property (@(posedge clk) disable iff (rst)
        !rd_drive |-> rdata == '0);
    a_r3_standby_undriven: assert property (@(posedge clk) disable iff (rst)
        (ce1_n || !ce2) |=> !rd_drive);
    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> !rd_drive && rdata == '0);
    a_r1_top_bit_source: assert property (@(posedge clk) disable iff (rst)
        (!ce1_n && ce2 && we_n && !oe_n && mux_ctl && $past(mux_ctl) && $past(mode) == MD_READ
         && $stable(addr_lo) && $stable(part_sel_in) && $changed(a12_in))
        |=> $stable(rdata));
endmodule

// File: tb/test_split_bank_sram.sv
module test_split_bank_sram;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] addr_lo = '0;
    logic        a12_in = 1'b0, part_sel_in = 1'b0, mux_ctl = 1'b0;
    logic        ce1_n = 1'b1, ce2 = 1'b0, oe_n = 1'b1, we_n = 1'b1;
    logic [23:0] wdata = '0;
    logic [23:0] rdata;
    logic        rd_drive, standby;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic        q_v [$];
    logic [23:0] q_d [$];
    string       q_t [$];
    logic [23:0] model [int];

    always #4 clk = ~clk;

    split_bank_sram i_split_bank_sram (
        .clk(clk), .rst(rst), .addr_lo(addr_lo), .a12_in(a12_in),
        .part_sel_in(part_sel_in), .mux_ctl(mux_ctl), .ce1_n(ce1_n), .ce2(ce2),
        .oe_n(oe_n), .we_n(we_n), .wdata(wdata), .rdata(rdata),
        .rd_drive(rd_drive), .standby(standby)
    );

    // driver: one call = one clock cycle of stimulus
    task automatic op(input bit c1n, input bit c2, input bit oen, input bit wen,
                      input bit mx, input bit a12, input bit ps, input int lo,
                      input logic [23:0] wd, input string tag);
        bit sel, rd;
        int eff;
        @(negedge clk);
        ce1_n = c1n; ce2 = c2; oe_n = oen; we_n = wen; mux_ctl = mx;
        a12_in = a12; part_sel_in = ps; addr_lo = 12'(lo); wdata = wd;
        sel = !c1n && c2;
        eff = ((mx ? int'(ps) : int'(a12)) << 12) | (lo & 12'hfff);
        rd  = sel && wen && !oen && !rst;
        q_v.push_back(rd);
        q_d.push_back(rd ? model[eff] : 24'h0);
        q_t.push_back(tag);
        if (sel && !wen && !rst) model[eff] = wd;
        #1;
        checks++;
        if (standby !== !sel) begin
            failures++;
            $display("FAIL R2 standby actual=%0b expected=%0b", standby, !sel);
        end
    endtask

    task automatic wr(input bit mx, input bit a12, input bit ps, input int lo,
                      input logic [23:0] wd, input bit oen, input string tag);
        op(1'b0, 1'b1, oen, 1'b0, mx, a12, ps, lo, wd, tag);
    endtask

    task automatic rdw(input bit mx, input bit a12, input bit ps, input int lo,
                       input string tag);
        op(1'b0, 1'b1, 1'b0, 1'b1, mx, a12, ps, lo, 24'h0, tag);
    endtask

    // monitor: compares each cycle's result against the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_v.size() > 0) begin
                logic        ev;
                logic [23:0] ed;
                string       et;
                ev = q_v.pop_front();
                ed = q_d.pop_front();
                et = q_t.pop_front();
                checks++;
                if (rd_drive !== ev || rdata !== ed) begin
                    failures++;
                    $display("FAIL %s drive/data actual=%0b/%h expected=%0b/%h",
                             et, rd_drive, rdata, ev, ed);
                end
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R8: reset state, even with a read request present
        op(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5, 24'h0, "R8");
        op(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5, 24'hDEAD00, "R8");
        op(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0, 24'h0, "R8");
        @(negedge clk);
        rst = 1'b0;
        q_v.push_back(1'b0); q_d.push_back(24'h0); q_t.push_back("R8");

        // R1/R5: four words via both sources; inactive candidate held opposite
        wr(1'b0, 1'b0, 1'b1, 12'h123, 24'hA0A0A0, 1'b1, "R5");
        wr(1'b0, 1'b1, 1'b0, 12'h123, 24'hA1A1A1, 1'b0, "R5");
        wr(1'b1, 1'b1, 1'b0, 12'h456, 24'hB0B0B0, 1'b1, "R1");
        wr(1'b1, 1'b0, 1'b1, 12'h456, 24'hB1B1B1, 1'b0, "R1");
        rdw(1'b0, 1'b0, 1'b1, 12'h123, "R1");
        rdw(1'b0, 1'b1, 1'b0, 12'h123, "R1");
        // R9: cross-path reads
        rdw(1'b1, 1'b0, 1'b1, 12'h123, "R9");
        rdw(1'b1, 1'b1, 1'b0, 12'h123, "R9");
        rdw(1'b0, 1'b0, 1'b1, 12'h456, "R9");
        rdw(1'b0, 1'b1, 1'b0, 12'h456, "R9");

        // R3: deselected writes and reads, each enable dropped alone
        op(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 12'h123, 24'h111111, "R3");
        op(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 12'h456, 24'h222222, "R3");
        op(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 12'h123, 24'h0, "R3");
        op(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 12'h123, 24'h0, "R3");
        op(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 12'h123, 24'h0, "R3");
        rdw(1'b0, 1'b1, 1'b0, 12'h123, "R3");
        rdw(1'b1, 1'b0, 1'b1, 12'h456, "R3");

        // R4: selected, both strobes high
        op(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 12'h123, 24'h333333, "R4");
        rdw(1'b0, 1'b0, 1'b0, 12'h123, "R4");

        // R10: back-to-back write then read
        wr(1'b1, 1'b0, 1'b1, 12'h789, 24'hC3C3C3, 1'b0, "R10");
        rdw(1'b1, 1'b0, 1'b1, 12'h789, "R10");
        wr(1'b1, 1'b0, 1'b1, 12'h789, 24'hC4C4C4, 1'b1, "R10");
        rdw(1'b0, 1'b1, 1'b1, 12'h789, "R10");

        // R7: idle cycle after a read returns zero
        op(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0, 24'h0, "R7");

        // boundaries: first and last words
        wr(1'b0, 1'b0, 1'b0, 12'h000, 24'h000001, 1'b1, "R5");
        wr(1'b1, 1'b0, 1'b1, 12'hFFF, 24'hFFFFFE, 1'b1, "R5");
        rdw(1'b1, 1'b0, 1'b0, 12'h000, "R6");
        rdw(1'b0, 1'b1, 1'b0, 12'hFFF, "R6");

        // column sweep across one row in each half
        for (int i = 0; i < 32; i++)
            wr(1'b1, 1'b0, i[0], 12'h2A0 + i, 24'h5A0000 + 24'(i * 257), 1'b1, "R5");
        for (int i = 0; i < 32; i++)
            rdw(1'b0, i[0], 1'b0, 12'h2A0 + i, "R6");

        op(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0, 24'h0, "R7");
        @(negedge clk);
        @(negedge clk);
        done = 1;
    end
endmodule